// File: doc/BRIEF.md
# Banked Semi-Parallel Class Score Engine

This block computes the fully connected stage of a small image classifier. It multiplies a long activation vector by a fixed weight matrix that has one column per output class. A fixed number of multiplier lanes share the work. The activation vector is spread over one small memory per lane, so every lane reads its operand in the same cycle. Each lane is paired with a weight source that yields one weight per (chunk, class) address. One pass over the lanes covers one row chunk of the matrix for one class. An adder tree with a register at every level reduces the lane products, and a saturating accumulator for each class sums the chunk partials.

A feature engine upstream fills the banks through a write port and then pulses `start`. When the schedule has drained, the block raises `out_valid` for one cycle, and all ten scores are final at that point. The scores hold until the next accepted start. The full-size network uses 147 lanes and 16 words per bank. The defaults here are a reduced setting (7 lanes, 4 words) for elaboration and simulation.

Top module: `fcmv_top`

## Requirements
- R1: While reset is active and right after it, `out_valid` is 0 and every score is 0.
- R2: A write with lane `b` and address `k` stores vector element number `k*LANES + b`.
- R3: The weight applied in lane `b` at weight address `a = chunk*10 + class` is `((29*b + 13*a + 7) mod 256) - 128`, a signed 9-bit value.
- R4: Each lane product is the full signed product of activation and weight, shifted arithmetically right by FRAC (default 4). Only its low 9 bits are kept, as a two's-complement value.
- R5: The lane products of one pass are summed modulo 2^9, which wraps in two's complement.
- R6: For each class, the pass results are accumulated in chunk order 0 to DEPTH-1 starting from 0. After every addition the total is clamped to [-256, 255].
- R7: An accepted start makes every score read 0 in the cycle after the edge that samples it.
- R8: `out_valid` is high for exactly one cycle. It is set by the (DEPTH*10 + ceil(log2(LANES)) + 1)-th rising edge after the edge that accepts start, which is the 44th edge for the defaults.
- R9: A start pulse that arrives while a computation or its drain is in progress is ignored. The pulse timing and the scores are unchanged.
- R10: When idle and without start, the scores hold their values. Score of class `c` sits at `scores[9*c +: 9]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Activation write strobe |
| wr_lane | input | $clog2(LANES) | Bank selected for the write |
| wr_addr | input | $clog2(DEPTH) | Word address inside the bank |
| wr_data | input | 9 | Signed activation value |
| start | input | 1 | Begin a computation when idle |
| out_valid | output | 1 | One-cycle pulse, scores final |
| scores | output | 90 | Ten signed 9-bit class scores |

## Verification
Two results are due at fixed distances from the accepting edge. The scores read zero at the first falling edge after the start edge. The completion pulse is due exactly 44 edges later, which is the schedule length plus one product register plus three tree levels. The bench counts edges from the one that samples start and checks `out_valid` at every falling edge against that count. It compares the ten scores with its own arithmetic model at the pulse and again a few cycles later. A second start injected mid-run must leave both the pulse position and the scores unchanged.

// File: rtl/fcmv_pkg.sv
package fcmv_pkg;
  localparam int DW    = 9;
  localparam int NCLS  = 10;
  localparam int CLS_W = $clog2(NCLS);

  typedef struct packed {
    logic             vld;
    logic             last;
    logic [CLS_W-1:0] cls;
  } tag_t;

  // Weight source for one lane at one weight address
  function automatic logic signed [DW-1:0] rom_weight(input int lane, input int addr);
    int v;
    v = ((lane * 29 + addr * 13 + 7) % 256) - 128;
    return v[DW-1:0];
  endfunction

  // Signed add clamped to the DW-bit range
  function automatic logic signed [DW-1:0] sat_add(input logic signed [DW-1:0] a,
                                                   input logic signed [DW-1:0] b);
    logic [DW:0] s;
    s = {a[DW-1], a} + {b[DW-1], b};
    if (s[DW] != s[DW-1])
      return s[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    return s[DW-1:0];
  endfunction
endpackage

// File: rtl/fcmv_act_banks.sv
module fcmv_act_banks
  import fcmv_pkg::*;
#(
  parameter int LANES = 7,
  parameter int DEPTH = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [LW-1:0]       wr_lane,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*DW-1:0] rd_flat
);
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          we;
    assign we = wr_en && (wr_lane == LW'(b));
    always_ff @(posedge clk) begin
      if (we) mem[wr_addr] <= wr_data;
    end
    assign rd_flat[b*DW +: DW] = mem[rd_addr];
  end
endmodule

// File: rtl/fcmv_lane_products.sv
module fcmv_lane_products
  import fcmv_pkg::*;
#(
  parameter int LANES = 7,
  parameter int DEPTH = 4,
  parameter int FRAC  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  tag_t                tag_in,
  input  logic [AW-1:0]       chunk,
  input  logic [LANES*DW-1:0] act_flat,
  output logic [LANES*DW-1:0] prod_flat,
  output tag_t                tag_out
);
  int waddr;
  always_comb waddr = int'(chunk) * NCLS + int'(tag_in.cls);

  logic [LANES*DW-1:0] prod_c;
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic signed [DW-1:0]   w;
    logic signed [2*DW-1:0] full;
    logic signed [2*DW-1:0] shifted;
    always_comb begin
      w       = rom_weight(b, waddr);
      full    = $signed(act_flat[b*DW +: DW]) * w;
      shifted = full >>> FRAC;
    end
    assign prod_c[b*DW +: DW] = shifted[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (tag_in.vld) prod_flat <= prod_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_out <= '0;
    else        tag_out <= tag_in;
  end
endmodule

// File: rtl/fcmv_sum_tree.sv
module fcmv_sum_tree
  import fcmv_pkg::*;
#(
  parameter int N = 7,
  localparam int LEVELS = (N > 1) ? $clog2(N) : 0,
  localparam int PADN   = 1 << LEVELS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*DW-1:0] in_flat,
  input  tag_t            in_tag,
  output logic [DW-1:0]   sum,
  output tag_t            out_tag
);
  for (genvar l = 0; l <= LEVELS; l++) begin : lvl
    localparam int CNT = PADN >> l;
    logic [CNT*DW-1:0] node;
    tag_t              tg;
    if (l == 0) begin : g_leaf
      always_comb begin
        node           = '0;
        node[N*DW-1:0] = in_flat;
      end
      assign tg = in_tag;
    end else begin : g_add
      logic [CNT*DW-1:0] sum_c;
      for (genvar i = 0; i < CNT; i++) begin : g_pair
        assign sum_c[i*DW +: DW] = lvl[l-1].node[(2*i)*DW +: DW]
                                 + lvl[l-1].node[(2*i+1)*DW +: DW];
      end
      always_ff @(posedge clk) begin
        node <= sum_c;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg <= '0;
        else        tg <= lvl[l-1].tg;
      end
    end
  end

  assign sum     = lvl[LEVELS].node[DW-1:0];
  assign out_tag = lvl[LEVELS].tg;
endmodule

// File: rtl/fcmv_class_accum.sv
module fcmv_class_accum
  import fcmv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [DW-1:0]      part,
  input  tag_t               tag,
  output logic [NCLS*DW-1:0] scores,
  output logic               done
);
  logic [NCLS*DW-1:0] acc_n;
  logic               done_n;

  always_comb begin
    acc_n  = scores;
    done_n = 1'b0;
    if (clear) begin
      acc_n = '0;
    end else if (tag.vld) begin
      for (int c = 0; c < NCLS; c++) begin
        if (tag.cls == CLS_W'(c))
          acc_n[c*DW +: DW] = sat_add(scores[c*DW +: DW], part);
      end
      done_n = tag.last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scores <= '0;
      done   <= 1'b0;
    end else begin
      scores <= acc_n;
      done   <= done_n;
    end
  end
endmodule

// File: rtl/fcmv_top.sv
module fcmv_top
  import fcmv_pkg::*;
#(
  parameter int LANES = 7,
  parameter int DEPTH = 4,
  parameter int FRAC  = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LW-1:0]      wr_lane,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               start,
  output logic               out_valid,
  output logic [NCLS*DW-1:0] scores
);
  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // schedule: class inner, chunk outer
  logic             busy_q, busy_n, issue_q, issue_n;
  logic [AW-1:0]    chunk_q, chunk_n;
  logic [CLS_W-1:0] cls_q, cls_n;
  logic             accept, last_issue, done;
  tag_t             issue_tag;

  assign accept     = start && !busy_q;
  assign last_issue = issue_q && (chunk_q == AW'(DEPTH-1)) && (cls_q == CLS_W'(NCLS-1));

  always_comb begin
    busy_n  = busy_q;
    issue_n = issue_q;
    chunk_n = chunk_q;
    cls_n   = cls_q;
    if (accept) begin
      busy_n  = 1'b1;
      issue_n = 1'b1;
      chunk_n = '0;
      cls_n   = '0;
    end else begin
      if (done) busy_n = 1'b0;
      if (issue_q) begin
        if (cls_q == CLS_W'(NCLS-1)) begin
          cls_n = '0;
          if (chunk_q == AW'(DEPTH-1)) issue_n = 1'b0;
          else                         chunk_n = chunk_q + 1'b1;
        end else begin
          cls_n = cls_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q  <= 1'b0;
      issue_q <= 1'b0;
      chunk_q <= '0;
      cls_q   <= '0;
    end else begin
      busy_q  <= busy_n;
      issue_q <= issue_n;
      chunk_q <= chunk_n;
      cls_q   <= cls_n;
    end
  end

  assign issue_tag = '{vld: issue_q, last: last_issue, cls: cls_q};

  logic [LANES*DW-1:0] act_flat, prod_flat;
  tag_t                prod_tag, sum_tag;
  logic [DW-1:0]       part;

  fcmv_act_banks #(.LANES(LANES), .DEPTH(DEPTH)) u_banks (
    .clk(clk), .wr_en(wr_en), .wr_lane(wr_lane), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(chunk_q), .rd_flat(act_flat)
  );

  fcmv_lane_products #(.LANES(LANES), .DEPTH(DEPTH), .FRAC(FRAC)) u_prod (
    .clk(clk), .rst_n(rst_sn), .tag_in(issue_tag), .chunk(chunk_q),
    .act_flat(act_flat), .prod_flat(prod_flat), .tag_out(prod_tag)
  );

  fcmv_sum_tree #(.N(LANES)) u_tree (
    .clk(clk), .rst_n(rst_sn), .in_flat(prod_flat), .in_tag(prod_tag),
    .sum(part), .out_tag(sum_tag)
  );

  fcmv_class_accum u_acc (
    .clk(clk), .rst_n(rst_sn), .clear(accept), .part(part), .tag(sum_tag),
    .scores(scores), .done(done)
  );

  assign out_valid = done;
endmodule

// File: rtl/fcmv_checker.sv
module fcmv_checker
  import fcmv_pkg::*;
#(
  parameter int LANES = 7,
  parameter int DEPTH = 4,
  localparam int LAT = DEPTH * NCLS + 1 + ((LANES > 1) ? $clog2(LANES) : 0)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               out_valid,
  input logic [NCLS*DW-1:0] scores
);
  logic [15:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start && !busy) cnt <= '0;
    else if (busy)           cnt <= cnt + 1'b1;
  end

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt == 16'(LAT)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (scores == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(scores));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || out_valid));
endmodule

bind fcmv_top fcmv_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q),
  .out_valid(out_valid), .scores(scores)
);

// File: tb/fcmv_top_test.sv
module fcmv_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 7;
  localparam int DEPTH = 4;
  localparam int NC    = 10;
  localparam int NEL   = LANES * DEPTH;
  localparam int LAT   = DEPTH * NC + 1 + $clog2(LANES);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_lane;
  logic [1:0]  wr_addr;
  logic [8:0]  wr_data;
  logic        start;
  logic        out_valid;
  logic [89:0] scores;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int vec [NEL];
  int exp_sc [NC];
  bit sat_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmv_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lane(wr_lane),
    .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
    .out_valid(out_valid), .scores(scores)
  );

  function automatic int wrap9(input int x);
    int m;
    m = x & 511;
    if (m >= 256) m -= 512;
    return m;
  endfunction

  function automatic int wgt(input int lane, input int addr);
    return ((lane * 29 + addr * 13 + 7) % 256) - 128;
  endfunction

  // R3 R4 R5 R6 reference arithmetic
  task automatic model();
    sat_hit = 0;
    for (int c = 0; c < NC; c++) begin
      int acc;
      acc = 0;
      for (int ch = 0; ch < DEPTH; ch++) begin
        int s;
        s = 0;
        for (int b = 0; b < LANES; b++)
          s += wrap9((vec[ch*LANES + b] * wgt(b, ch*NC + c)) >>> 4);
        s = wrap9(s);
        acc = acc + s;
        if (acc > 255)  begin acc = 255;  sat_hit = 1; end
        if (acc < -256) begin acc = -256; sat_hit = 1; end
      end
      exp_sc[c] = acc;
    end
  endtask

  function automatic int score_of(input int c);
    return int'($signed(scores[c*9 +: 9]));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R2: element i goes to lane i%LANES, address i/LANES
  task automatic load_vec();
    for (int i = 0; i < NEL; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_lane = 3'(i % LANES);
      wr_addr = 2'(i / LANES);
      wr_data = 9'(vec[i]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input bit inject);
    model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);          // after accepting edge, k = 0
    start = 1'b0;
    for (int c = 0; c < NC; c++) check(score_of(c) == 0, "R7 clear", score_of(c), 0);
    for (int k = 1; k <= LAT + 3; k++) begin
      @(negedge clk);
      if (inject && k == 5) start = 1'b1;
      if (inject && k == 6) start = 1'b0;
      check(out_valid == (k == LAT), inject ? "R9 R8 pulse" : "R8 pulse",
            int'(out_valid), int'(k == LAT));
      if (k == LAT)
        for (int c = 0; c < NC; c++)
          check(score_of(c) == exp_sc[c], "R4 R5 R6 score", score_of(c), exp_sc[c]);
    end
    for (int c = 0; c < NC; c++)
      check(score_of(c) == exp_sc[c], "R10 hold", score_of(c), exp_sc[c]);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_lane = '0; wr_addr = '0; wr_data = '0; start = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    check(scores == '0, "R1 scores", int'(scores != '0), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after", int'(out_valid), 0);

    // small ramp
    for (int i = 0; i < NEL; i++) vec[i] = (i % 7) - 3;
    load_vec();
    run(1'b0);

    // pseudo-random full range
    for (int i = 0; i < NEL; i++) vec[i] = ((i * 73 + 11) % 512) - 256;
    load_vec();
    run(1'b1);

    // search a pattern that drives the accumulator into clamping (R6)
    begin
      bit found;
      found = 0;
      for (int seed = 0; seed < 200 && !found; seed++) begin
        for (int i = 0; i < NEL; i++) vec[i] = (((i + 3) * (seed * 37 + 101) + seed) % 512) - 256;
        model();
        found = sat_hit;
      end
      check(found, "R6 saturating stimulus", int'(found), 1);
    end
    load_vec();
    run(1'b0);

    // all zero
    for (int i = 0; i < NEL; i++) vec[i] = 0;
    load_vec();
    run(1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule